// File: doc/BRIEF.md
# Programmable Flag Offset Register Loader

This block keeps the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against. Each threshold is wider than the shared 9-bit data port, so it is split into a low byte slot and a narrow high slot. A rotating selector steps through four slots: empty-low, empty-high, full-low, full-high. Software loads the thresholds by holding the program pin low and pulsing the first write enable. It reads them back in the same slot order through the read side.

The load path runs on the write clock. The readback output register runs on the read clock, and each side has its own rotating selector. When the program pin is high, the block leaves both thresholds alone and forwards the enables as plain FIFO write and read strobes. The assembled thresholds drive the flag logic continuously.

Top module: `pfo_loader`

## Requirements
- R1: While rst_ni is low, empty_ofs_o and full_ofs_o equal DEF_OFS (7), rd_data_o is zero, and both selectors return to slot 0 (empty-low).
- R2: With prog_ni low and wen1_ni low, each rising wclk_i edge writes din_i into the selected slot. The slots are taken in the order 0 empty-low, 1 empty-high, 2 full-low, 3 full-high, and the write selector then advances by one.
- R3: After slot 3 the write selector wraps to slot 0.
- R4: With prog_ni low and wen1_ni high, a wclk_i edge changes neither threshold and does not advance the write selector.
- R5: With prog_ni high, both thresholds are untouched and the write selector holds. fifo_wr_o is high exactly when wen1_ni is low.
- R6: A low slot stores din_i[7:0] as threshold bits [7:0]. A high slot stores din_i[4:0] as threshold bits [12:8].
- R7: With prog_ni, ren1_ni and ren2_ni all low, each rising rclk_i edge loads the selected slot into rd_data_o, zero-extended to 9 bits, in the same slot order as R2. The read selector then advances.
- R8: If prog_ni, ren1_ni or ren2_ni is high, rd_data_o holds its value and the read selector holds.
- R9: The read selector wraps from slot 3 to slot 0, and readback never alters the thresholds.
- R10: fifo_rd_o is high exactly when prog_ni is high and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock, loads slots |
| rclk_i | input | 1 | Read clock, readback register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_ni | input | 1 | Low: program/readback access; high: second write enable |
| wen1_ni | input | 1 | First write enable, active low |
| ren1_ni | input | 1 | First read enable, active low |
| ren2_ni | input | 1 | Second read enable, active low |
| din_i | input | 9 | Shared data input |
| rd_data_o | output | 9 | Readback output register |
| empty_ofs_o | output | 13 | Assembled empty threshold |
| full_ofs_o | output | 13 | Assembled full threshold |
| fifo_wr_o | output | 1 | Forwarded FIFO write strobe |
| fifo_rd_o | output | 1 | Forwarded FIFO read strobe |

## Verification
A write selector stuck at one slot or advancing wrongly shows on the threshold ports one wclk_i edge after the load that lands in the wrong field. A skipped wrap appears at the fifth load. A read selector out of step shows in rd_data_o on the very next readback, because the expected slot sequence is known. A hold condition that leaks shows as a changed threshold or a changed readback value one edge after the ignored cycle. A bad reset value is visible on the threshold ports while reset is still low.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
  localparam int unsigned SLOT_N = 4;
  localparam int unsigned SEL_W  = 2;

  // order matters: it is the load and readback sequence
  typedef enum logic [SEL_W-1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  function automatic slot_e next_slot(slot_e s);
    slot_e n;
    unique case (s)
      SLOT_EMPTY_LO: n = SLOT_EMPTY_HI;
      SLOT_EMPTY_HI: n = SLOT_FULL_LO;
      SLOT_FULL_LO:  n = SLOT_FULL_HI;
      default:       n = SLOT_EMPTY_LO;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pfo_ptr.sv
module pfo_ptr
  import pfo_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  output slot_e sel_o
);
  slot_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SLOT_EMPTY_LO;
    else if (step_i) sel_q <= next_slot(sel_q);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/pfo_regs.sv
module pfo_regs
  import pfo_pkg::*;
#(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned OFS_W   = 13,
  parameter int unsigned DEF_OFS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  slot_e             sel_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [OFS_W-1:0]  empty_ofs_o,
  output logic [OFS_W-1:0]  full_ofs_o
);
  localparam int unsigned HI_W = OFS_W - LO_W;
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

  logic [OFS_W-1:0] ofs [2];

  // g = 0: empty threshold, g = 1: full threshold; sel[1] picks, sel[0] picks half
  for (genvar g = 0; g < 2; g++) begin : g_ofs
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            hit;

    assign hit = we_i && (sel_i[1] == 1'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= DEF_V[LO_W-1:0];
        hi_q <= DEF_V[OFS_W-1:LO_W];
      end else if (hit) begin
        if (sel_i[0]) hi_q <= din_i[HI_W-1:0];
        else          lo_q <= din_i[LO_W-1:0];
      end
    end

    assign ofs[g] = {hi_q, lo_q};
  end

  assign empty_ofs_o = ofs[0];
  assign full_ofs_o  = ofs[1];
endmodule

// File: rtl/pfo_rdmux.sv
module pfo_rdmux
  import pfo_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned OFS_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  slot_e             sel_i,
  input  logic [OFS_W-1:0]  empty_ofs_i,
  input  logic [OFS_W-1:0]  full_ofs_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned HI_W = OFS_W - LO_W;

  logic [DATA_W-1:0] slot_val;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    unique case (sel_i)
      SLOT_EMPTY_LO: slot_val = DATA_W'(empty_ofs_i[LO_W-1:0]);
      SLOT_EMPTY_HI: slot_val = DATA_W'(empty_ofs_i[OFS_W-1:LO_W]);
      SLOT_FULL_LO:  slot_val = DATA_W'(full_ofs_i[LO_W-1:0]);
      default:       slot_val = DATA_W'(full_ofs_i[OFS_W-1:LO_W]);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (re_i) rd_q <= slot_val;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/pfo_loader.sv
module pfo_loader
  import pfo_pkg::*;
#(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned OFS_W   = 13,
  parameter int unsigned DEF_OFS = 7
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              prog_ni,
  input  logic              wen1_ni,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [OFS_W-1:0]  empty_ofs_o,
  output logic [OFS_W-1:0]  full_ofs_o,
  output logic              fifo_wr_o,
  output logic              fifo_rd_o
);
  logic  load_we;
  logic  rdbk_re;
  slot_e w_sel;
  slot_e r_sel;

  assign load_we = !prog_ni && !wen1_ni;
  assign rdbk_re = !prog_ni && !ren1_ni && !ren2_ni;

  // program pin high: plain second write enable, offsets untouched
  assign fifo_wr_o = prog_ni && !wen1_ni;
  assign fifo_rd_o = prog_ni && !ren1_ni && !ren2_ni;

  pfo_ptr u_wptr (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .step_i (load_we),
    .sel_o  (w_sel)
  );

  pfo_ptr u_rptr (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .step_i (rdbk_re),
    .sel_o  (r_sel)
  );

  pfo_regs #(
    .DATA_W (DATA_W),
    .LO_W   (LO_W),
    .OFS_W  (OFS_W),
    .DEF_OFS(DEF_OFS)
  ) u_regs (
    .clk_i       (wclk_i),
    .rst_ni      (rst_ni),
    .we_i        (load_we),
    .sel_i       (w_sel),
    .din_i       (din_i),
    .empty_ofs_o (empty_ofs_o),
    .full_ofs_o  (full_ofs_o)
  );

  pfo_rdmux #(
    .DATA_W(DATA_W),
    .LO_W  (LO_W),
    .OFS_W (OFS_W)
  ) u_rdmux (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .re_i        (rdbk_re),
    .sel_i       (r_sel),
    .empty_ofs_i (empty_ofs_o),
    .full_ofs_i  (full_ofs_o),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/pfo_loader_chk.sv
module pfo_loader_chk #(
  parameter int unsigned DATA_W  = 9,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned OFS_W   = 13,
  parameter int unsigned DEF_OFS = 7
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              prog_ni,
  input logic              wen1_ni,
  input logic              ren1_ni,
  input logic              ren2_ni,
  input logic [DATA_W-1:0] din_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [OFS_W-1:0]  empty_ofs_o,
  input logic [OFS_W-1:0]  full_ofs_o,
  input logic [1:0]        w_sel
);
  localparam int unsigned HI_W = OFS_W - LO_W;
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

  // R1
  always @(posedge wclk_i) begin
    if (!rst_ni) begin
      reset_default_chk: assert (empty_ofs_o == DEF_V && full_ofs_o == DEF_V);
    end
  end

  // R1
  always @(posedge rclk_i) begin
    if (!rst_ni) begin
      reset_rdata_chk: assert (rd_data_o == '0);
    end
  end

  // R2
  first_slot_load_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!prog_ni && !wen1_ni && w_sel == 2'd0) |=> empty_ofs_o[LO_W-1:0] == $past(din_i[LO_W-1:0]));

  // R6
  high_slot_field_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!prog_ni && !wen1_ni && w_sel == 2'd3) |=> full_ofs_o[OFS_W-1:LO_W] == $past(din_i[HI_W-1:0]));

  // R3
  wsel_wrap_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!prog_ni && !wen1_ni && w_sel == 2'd3) |=> w_sel == 2'd0);

  // R4
  ofs_hold_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (prog_ni || wen1_ni) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o) && $stable(w_sel)));

  // R8
  rdata_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (prog_ni || ren1_ni || ren2_ni) |=> $stable(rd_data_o));

  // R7
  rdata_zext_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:LO_W] == '0);
endmodule

bind pfo_loader pfo_loader_chk #(
  .DATA_W (DATA_W),
  .LO_W   (LO_W),
  .OFS_W  (OFS_W),
  .DEF_OFS(DEF_OFS)
) chk_i (
  .wclk_i      (wclk_i),
  .rclk_i      (rclk_i),
  .rst_ni      (rst_ni),
  .prog_ni     (prog_ni),
  .wen1_ni     (wen1_ni),
  .ren1_ni     (ren1_ni),
  .ren2_ni     (ren2_ni),
  .din_i       (din_i),
  .rd_data_o   (rd_data_o),
  .empty_ofs_o (empty_ofs_o),
  .full_ofs_o  (full_ofs_o),
  .w_sel       (w_sel)
);

// File: tb/pfo_loader_tb_top.sv
`timescale 1ns/1ps
module pfo_loader_tb_top;
  localparam int DATA_W = 9;
  localparam int OFS_W  = 13;

  logic              wclk = 1'b0;
  logic              rclk = 1'b0;
  logic              rst_n = 1'b1;
  logic              prog_n = 1'b1;
  logic              wen1_n = 1'b1;
  logic              ren1_n = 1'b1;
  logic              ren2_n = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] rd_data;
  logic [OFS_W-1:0]  empty_ofs;
  logic [OFS_W-1:0]  full_ofs;
  logic              fifo_wr;
  logic              fifo_rd;

  int n_run  = 0;
  int n_fail = 0;

  // bench model
  logic [OFS_W-1:0] m_e, m_f;
  int               m_wp, m_rp;

  always #10 wclk = ~wclk;
  initial begin
    #7;
    forever #10 rclk = ~rclk;
  end

  pfo_loader dut_i (
    .wclk_i      (wclk),
    .rclk_i      (rclk),
    .rst_ni      (rst_n),
    .prog_ni     (prog_n),
    .wen1_ni     (wen1_n),
    .ren1_ni     (ren1_n),
    .ren2_ni     (ren2_n),
    .din_i       (din),
    .rd_data_o   (rd_data),
    .empty_ofs_o (empty_ofs),
    .full_ofs_o  (full_ofs),
    .fifo_wr_o   (fifo_wr),
    .fifo_rd_o   (fifo_rd)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_ofs(input string req);
    check(req, int'(empty_ofs), int'(m_e));
    check(req, int'(full_ofs), int'(m_f));
  endtask

  function automatic int slot_val(input int s);
    case (s)
      0: return int'(m_e[7:0]);
      1: return int'(m_e[12:8]);
      2: return int'(m_f[7:0]);
      default: return int'(m_f[12:8]);
    endcase
  endfunction

  task automatic do_reset();
    @(negedge wclk);
    rst_n = 1'b0;
    prog_n = 1'b1; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    m_e = 13'd7; m_f = 13'd7; m_wp = 0; m_rp = 0;
    @(negedge wclk);
    check("R1 empty default", int'(empty_ofs), 7);
    check("R1 full default", int'(full_ofs), 7);
    check("R1 rdata zero", int'(rd_data), 0);
    rst_n = 1'b1;
  endtask

  // one program load through the write side
  task automatic do_load(input logic [8:0] d);
    @(negedge wclk);
    prog_n = 1'b0; wen1_n = 1'b0; din = d;
    @(negedge wclk);
    wen1_n = 1'b1;
    case (m_wp)
      0: m_e[7:0]  = d[7:0];
      1: m_e[12:8] = d[4:0];
      2: m_f[7:0]  = d[7:0];
      default: m_f[12:8] = d[4:0];
    endcase
    m_wp = (m_wp + 1) % 4;
  endtask

  task automatic do_read(input string req);
    int exp;
    exp = slot_val(m_rp);
    @(negedge rclk);
    prog_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    check(req, int'(rd_data), exp);
    m_rp = (m_rp + 1) % 4;
  endtask

  task automatic t_reset();
    do_reset();
    #1 check("R5 fifo_wr idle", int'(fifo_wr), 0);
    check("R10 fifo_rd idle", int'(fifo_rd), 0);
  endtask

  task automatic t_write_order();
    do_load(9'h1A5); check_ofs("R2 slot0 empty-lo");
    do_load(9'h0F3); check_ofs("R6 slot1 empty-hi takes din[4:0]");
    do_load(9'h15C); check_ofs("R2 slot2 full-lo");
    do_load(9'h1E9); check_ofs("R6 slot3 full-hi takes din[4:0]");
    check("R6 empty assembled", int'(empty_ofs), 13'h13A5);
    check("R6 full assembled", int'(full_ofs), 13'h095C);
  endtask

  task automatic t_wrap();
    do_load(9'h0C3);
    check("R3 wrap to empty-lo", int'(empty_ofs), 13'h13C3);
    check_ofs("R3 full untouched");
  endtask

  task automatic t_hold_wen();
    for (int i = 0; i < 3; i++) begin
      @(negedge wclk);
      prog_n = 1'b0; wen1_n = 1'b1; din = 9'(9'h111 * (i + 1));
    end
    @(negedge wclk);
    check_ofs("R4 wen1 high no change");
    do_load(9'h01F);
    check("R4 selector held, next slot empty-hi", int'(empty_ofs), 13'h1FC3);
  endtask

  task automatic t_prog_high();
    @(negedge wclk);
    prog_n = 1'b1; wen1_n = 1'b0; din = 9'h0AA;
    #1 check("R5 fifo_wr forwarded", int'(fifo_wr), 1);
    @(negedge wclk);
    din = 9'h055;
    @(negedge wclk);
    wen1_n = 1'b1;
    #1 check("R5 fifo_wr released", int'(fifo_wr), 0);
    check_ofs("R5 offsets untouched");
    do_load(9'h0AB);
    check("R5 selector held, next slot full-lo", int'(full_ofs), 13'h09AB);
  endtask

  task automatic t_readback();
    do_read("R7 read slot0");
    do_read("R7 read slot1");
    do_read("R7 read slot2");
    do_read("R7 read slot3");
    do_read("R9 read wrap slot0");
    check_ofs("R9 readback leaves offsets");
  endtask

  task automatic t_read_hold();
    int prev;
    prev = int'(rd_data);
    @(negedge rclk);
    prog_n = 1'b0; ren1_n = 1'b0; ren2_n = 1'b1;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b0;
    @(negedge rclk);
    check("R8 one enable high holds", int'(rd_data), prev);
    prog_n = 1'b1; ren1_n = 1'b0; ren2_n = 1'b0;
    #1 check("R10 fifo_rd forwarded", int'(fifo_rd), 1);
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    #1 check("R10 fifo_rd released", int'(fifo_rd), 0);
    check("R8 program pin high holds", int'(rd_data), prev);
    do_read("R8 read selector held");
  endtask

  task automatic t_mid_reset();
    do_load(9'h0FF);
    do_reset();
    do_load(9'h042);
    check("R1 write selector back to slot0", int'(empty_ofs), 13'h0042);
    do_read("R1 read selector back to slot0");
  endtask

  initial begin
    #3 rst_n = 1'b0;
    m_e = 13'd7; m_f = 13'd7; m_wp = 0; m_rp = 0;
    t_reset();
    t_write_order();
    t_wrap();
    t_hold_wen();
    t_prog_high();
    t_readback();
    t_read_hold();
    t_mid_reset();
    #40;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule